// File: doc/BRIEF.md
# Operating-Mode Command and Write-Protect Register Bank

This block is a small register bank inside a device controller. A simple synchronous bus writes and reads three registers. The command register (offset 91h) and the debug register (offset 92h) hold self-clearing bits. Each write to one of these bits produces a one-cycle command. The commands move a two-state operating mode between normal and fail-safe, clear fault flags, or inject an error. The lock register (offset 93h) holds write-protect bits for three register groups elsewhere in the chip.

An injected error sets the error fault flag and drives the active-low error pin low for a fixed number of ticks of a slow timing enable. With the defaults this is 50 ticks of a 1 MHz enable, which gives 50 µs. An injection is honoured only in normal mode, and a new injection during an active pulse restarts the count. Each lock bit is combined with a write strobe whose address falls in that group's range. The result is one write-enable output per group, used by the registers that live outside this bank.

Top module: `fsr_top`

## Requirements
- R1: After reset the mode is normal (`failsafe` = 0), `fault_flags` equals 0001b (only the power-on flag), `err_n` is 1, and the lock register reads 03h.
- R2: The lock register at 93h stores bit 0 (output-current group lock), bit 1 (configuration group lock) and bit 2 (brightness group lock). Bits 7:3 always read 0 and ignore writes.
- R3: A group's write enable is 1 during the cycle of a bus write whose address is in that group's range, and only while its lock bit is 0. The ranges are output-current 00h–1Fh, brightness 20h–3Fh and configuration 40h–5Fh.
- R4: Writing 93h has effect only on the lock bits, and the new lock value governs the next write.
- R5: Writing a 1 to bit 1 of 92h puts the block into fail-safe mode (`failsafe` = 1) from the next cycle.
- R6: Writing a 1 to bit 2 of 91h returns the block to normal mode. If force and exit are requested in the same cycle, force wins.
- R7: Writing a 1 to bit 0 of 92h in normal mode sets the error flag (`fault_flags` bit 1). It also holds `err_n` low from the next cycle for exactly `PULSE_TICKS` cycles in which `tick` is 1.
- R8: The same injection has no effect in fail-safe mode: the error flag stays 0 and `err_n` stays 1.
- R9: An injection while a pulse is active reloads the count to the full `PULSE_TICKS`.
- R10: Writing a 1 to bit 0 of 91h clears only the power-on flag (`fault_flags` bit 0).
- R11: Writing a 1 to bit 1 of 91h clears every fault flag. An external fault input bit (`ext_fault[i]` sets `fault_flags` bit i+2) that is high in the same cycle wins over the clear.
- R12: Reads of 91h, 92h and of any unmapped address return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tick | input | 1 | Slow timing enable for the error pulse |
| ext_fault | input | NUM_EXT_FAULTS (2) | Fault set requests from detection logic |
| fault_flags | output | NUM_EXT_FAULTS+2 (4) | Bit 0 power-on, bit 1 error, upper bits external |
| failsafe | output | 1 | 1 while in fail-safe mode |
| err_n | output | 1 | Active-low error pin |
| iout_wr_en | output | 1 | Write enable for the output-current group |
| conf_wr_en | output | 1 | Write enable for the configuration group |
| brt_wr_en | output | 1 | Write enable for the brightness group |

## Verification
The write gating is tried with writes into each group's range under the reset lock value, with all locks cleared and with all locks set. This separates a wrong bit-to-group mapping from a wrong address range. The error pulse is measured one tick short of its length and at its length, and again after a mid-pulse re-injection. This distinguishes an off-by-one count from a restart that does not reload. The fault-flag tests clear the power-on flag alone and then clear everything, and they hold an external fault high during a clear-all. This tells a selective clear from a global one and shows which of set and clear wins. Injection is repeated in fail-safe mode, which shows that the mode gate is applied.

// File: rtl/fsr_pkg.sv
// Package: shared widths, the operating-mode encoding and the
// decoded command bundle used by every module of the register bank.
package fsr_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int NUM_GROUPS = 3;

    typedef enum logic {
        MODE_NORMAL   = 1'b0,
        MODE_FAILSAFE = 1'b1
    } op_mode_t;

    // One-cycle commands decoded from writes to self-clearing bits.
    typedef struct packed {
        logic exit_fs;
        logic clr_all;
        logic clr_por;
        logic force_fs;
        logic force_err;
    } cmd_t;
endpackage

// File: rtl/fsr_bus_decode.sv
// Module: fsr_bus_decode
// Decodes bus writes into one-cycle commands (the self-clearing bits never
// hold state), keeps the lock register and forms read data.
// Assumes one write per cycle and combinational read of bus_addr.
module fsr_bus_decode
    import fsr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'h91,
    parameter logic [ADDR_W-1:0] DBG_ADDR  = 8'h92,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h93,
    parameter logic [NUM_GROUPS-1:0] LOCK_RST = 3'b011
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output cmd_t                  cmd,
    output logic [NUM_GROUPS-1:0] lock_q,
    output logic [DATA_W-1:0]     bus_rdata
);
    localparam int PAD_W = DATA_W - NUM_GROUPS;

    logic wr_clr, wr_dbg, wr_lock;

    // Address match for the three registers of this bank.
    always_comb begin
        wr_clr  = bus_wr && (bus_addr == CLR_ADDR);
        wr_dbg  = bus_wr && (bus_addr == DBG_ADDR);
        wr_lock = bus_wr && (bus_addr == LOCK_ADDR);
    end

    // Self-clearing bits become single-cycle command pulses.
    always_comb begin
        cmd.exit_fs   = wr_clr && bus_wdata[2];
        cmd.clr_all   = wr_clr && bus_wdata[1];
        cmd.clr_por   = wr_clr && bus_wdata[0];
        cmd.force_fs  = wr_dbg && bus_wdata[1];
        cmd.force_err = wr_dbg && bus_wdata[0];
    end

    // Lock register: only the implemented low bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= LOCK_RST;
        end else if (wr_lock) begin
            lock_q <= bus_wdata[NUM_GROUPS-1:0];
        end
    end

    // Read mux: only the lock register returns nonzero data.
    always_comb begin
        if (bus_addr == LOCK_ADDR) begin
            bus_rdata = {{PAD_W{1'b0}}, lock_q};
        end else begin
            bus_rdata = '0;
        end
    end

    assert_lock_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lock |=> (lock_q == $past(bus_wdata[NUM_GROUPS-1:0])));
    assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lock |=> $stable(lock_q));
endmodule

// File: rtl/fsr_mode_fsm.sv
// Module: fsr_mode_fsm
// Two-state operating mode. Resets into normal; force has priority over exit.
// Assumes commands are single-cycle pulses.
module fsr_mode_fsm
    import fsr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     force_fs,
    input  logic     exit_fs,
    output op_mode_t mode
);
    op_mode_t mode_nx;

    // Next mode: force wins over exit, otherwise hold.
    always_comb begin
        mode_nx = mode;
        if (force_fs) begin
            mode_nx = MODE_FAILSAFE;
        end else if (exit_fs) begin
            mode_nx = MODE_NORMAL;
        end
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_NORMAL;
        end else begin
            mode <= mode_nx;
        end
    end

    assert_force_enters_fs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        force_fs |=> (mode == MODE_FAILSAFE));
    assert_exit_to_normal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_fs && !force_fs) |=> (mode == MODE_NORMAL));
    assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!exit_fs && !force_fs) |=> $stable(mode));
endmodule

// File: rtl/fsr_pulse_timer.sv
// Module: fsr_pulse_timer
// Holds 'active' high for PULSE_TICKS tick-enabled cycles after 'start'.
// A start while active reloads the full count. Assumes PULSE_TICKS >= 1.
module fsr_pulse_timer #(
    parameter int PULSE_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic active
);
    localparam int CNT_W = $clog2(PULSE_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_TICKS);

    logic [CNT_W-1:0] cnt;

    // Down counter: load on start, step down on each tick while nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_LOAD;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Pulse is active while ticks remain.
    always_comb begin
        active = (cnt != '0);
    end

    assert_start_reloads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt == CNT_LOAD));
    assert_tick_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !start && (cnt != '0)) |=> (cnt == $past(cnt) - 1'b1));
    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start) |=> $stable(cnt));
endmodule

// File: rtl/fsr_fault_flags.sv
// Module: fsr_fault_flags
// Sticky fault flags: bit 0 power-on (set by reset), bit 1 injected error,
// upper bits external. A set request wins over a clear in the same cycle.
module fsr_fault_flags #(
    parameter int NUM_EXT = 2,
    localparam int NUM_FLAGS = NUM_EXT + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_err,
    input  logic [NUM_EXT-1:0]   ext_set,
    input  logic                 clr_all,
    input  logic                 clr_por,
    output logic [NUM_FLAGS-1:0] flags
);
    logic               por_q;
    logic               err_q;
    logic [NUM_EXT-1:0] ext_q;

    // Power-on flag: set by reset, cleared by either clear command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_q <= 1'b1;
        end else if (clr_por || clr_all) begin
            por_q <= 1'b0;
        end
    end

    // Error flag: set by an accepted injection, cleared by clear-all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (set_err) begin
            err_q <= 1'b1;
        end else if (clr_all) begin
            err_q <= 1'b0;
        end
    end

    // External flags, one per input bit, set dominant.
    for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ext_q[i] <= 1'b0;
            end else if (ext_set[i]) begin
                ext_q[i] <= 1'b1;
            end else if (clr_all) begin
                ext_q[i] <= 1'b0;
            end
        end
    end

    // Flag vector layout.
    always_comb begin
        flags = {ext_q, err_q, por_q};
    end

    assert_clr_por_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_por |=> !por_q);
    assert_clr_por_keeps_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_por && !clr_all && !set_err) |=> (err_q == $past(err_q)));
    assert_clr_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !set_err && (ext_set == '0)) |=> (flags == '0));
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |=> err_q);
endmodule

// File: rtl/fsr_write_gate.sv
// Module: fsr_write_gate
// One write enable per register group: bus write inside the group's address
// range and the group's lock bit clear. Ranges given as packed base/limit.
module fsr_write_gate
    import fsr_pkg::*;
#(
    parameter logic [NUM_GROUPS*ADDR_W-1:0] GROUP_BASE  = {8'h20, 8'h40, 8'h00},
    parameter logic [NUM_GROUPS*ADDR_W-1:0] GROUP_LIMIT = {8'h3F, 8'h5F, 8'h1F}
) (
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [NUM_GROUPS-1:0] lock,
    output logic [NUM_GROUPS-1:0] wr_en
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam logic [ADDR_W-1:0] BASE = GROUP_BASE[g*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] SPAN = GROUP_LIMIT[g*ADDR_W +: ADDR_W] - BASE;
        logic [ADDR_W-1:0] offs;

        // Range test by wrapped offset, which avoids a compare against zero.
        always_comb begin
            offs     = bus_addr - BASE;
            wr_en[g] = bus_wr && !lock[g] && (offs <= SPAN);
        end
    end
endmodule

// File: rtl/fsr_top.sv
// Module: fsr_top
// Command, debug and lock register bank with a normal/fail-safe mode,
// fault flags, a timed active-low error pulse and per-group write gating.
// Assumes tick is a single-cycle enable of the slow time base.
module fsr_top
    import fsr_pkg::*;
#(
    parameter int NUM_EXT_FAULTS = 2,
    parameter int PULSE_TICKS    = 50
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [7:0]                  bus_addr,
    input  logic [7:0]                  bus_wdata,
    output logic [7:0]                  bus_rdata,
    input  logic                        tick,
    input  logic [NUM_EXT_FAULTS-1:0]   ext_fault,
    output logic [NUM_EXT_FAULTS+1:0]   fault_flags,
    output logic                        failsafe,
    output logic                        err_n,
    output logic                        iout_wr_en,
    output logic                        conf_wr_en,
    output logic                        brt_wr_en
);
    cmd_t                  cmd;
    logic [NUM_GROUPS-1:0] lock_q;
    logic [NUM_GROUPS-1:0] grp_wr_en;
    op_mode_t              mode;
    logic                  err_start;
    logic                  pulse_active;

    fsr_bus_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cmd       (cmd),
        .lock_q    (lock_q),
        .bus_rdata (bus_rdata)
    );

    fsr_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .force_fs (cmd.force_fs),
        .exit_fs  (cmd.exit_fs),
        .mode     (mode)
    );

    // Injection is honoured only in normal mode.
    always_comb begin
        err_start = cmd.force_err && (mode == MODE_NORMAL);
    end

    fsr_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (err_start),
        .tick   (tick),
        .active (pulse_active)
    );

    fsr_fault_flags #(.NUM_EXT(NUM_EXT_FAULTS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_err (err_start),
        .ext_set (ext_fault),
        .clr_all (cmd.clr_all),
        .clr_por (cmd.clr_por),
        .flags   (fault_flags)
    );

    fsr_write_gate u_gate (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .lock     (lock_q),
        .wr_en    (grp_wr_en)
    );

    // Output mapping: group 0 output current, 1 configuration, 2 brightness.
    always_comb begin
        iout_wr_en = grp_wr_en[0];
        conf_wr_en = grp_wr_en[1];
        brt_wr_en  = grp_wr_en[2];
        failsafe   = (mode == MODE_FAILSAFE);
        err_n      = !pulse_active;
    end

    assert_fs_blocks_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (failsafe && err_n && !cmd.force_err) |=> err_n);
    assert_fs_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (failsafe && cmd.force_err && err_n && !fault_flags[1]) |=> (err_n && !fault_flags[1]));
    assert_inject_pulls_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!failsafe && cmd.force_err) |=> (!err_n && fault_flags[1]));
    assert_gate_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({iout_wr_en, conf_wr_en, brt_wr_en}));
endmodule

// File: tb/fsr_top_bench.sv
// Directed bench for fsr_top: one task per scenario, each checking itself.
module fsr_top_bench;
    localparam int NE = 2;
    localparam int PT = 50;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          tick = 1'b0;
    logic [NE-1:0] ext_fault = '0;
    logic [NE+1:0] fault_flags;
    logic          failsafe, err_n, iout_wr_en, conf_wr_en, brt_wr_en;

    int   n_checks = 0;
    int   n_fail = 0;
    logic [2:0] seen_en;

    always #2.5 clk = ~clk;

    fsr_top #(.NUM_EXT_FAULTS(NE), .PULSE_TICKS(PT)) u_fsr_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
        .ext_fault(ext_fault), .fault_flags(fault_flags), .failsafe(failsafe),
        .err_n(err_n), .iout_wr_en(iout_wr_en), .conf_wr_en(conf_wr_en),
        .brt_wr_en(brt_wr_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One-cycle write; captures the group enables {brt,conf,iout} mid-cycle.
    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1 seen_en = {brt_wr_en, conf_wr_en, iout_wr_en};
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        do_reset();
        check("R1 failsafe", failsafe, 0);
        check("R1 flags", fault_flags, 4'b0001);
        check("R1 err_n", err_n, 1);
        bus_read(8'h93, d);
        check("R1 lock", d, 8'h03);
    endtask

    task automatic t_lock_gating();
        logic [7:0] d;
        do_reset();
        bus_write(8'h05, 8'hAA);
        check("R3 iout locked", seen_en, 3'b000);
        bus_write(8'h4F, 8'hAA);
        check("R3 conf locked", seen_en, 3'b000);
        bus_write(8'h3F, 8'hAA);
        check("R3 brt open", seen_en, 3'b100);
        bus_write(8'h93, 8'h00);
        bus_write(8'h1F, 8'h11);
        check("R4 iout unlocked", seen_en, 3'b001);
        bus_write(8'h40, 8'h11);
        check("R4 conf unlocked", seen_en, 3'b010);
        bus_write(8'h60, 8'h11);
        check("R3 unmapped", seen_en, 3'b000);
        bus_write(8'h93, 8'hFC);
        bus_read(8'h93, d);
        check("R2 reserved", d, 8'h04);
        bus_write(8'h20, 8'h11);
        check("R2 brt locked", seen_en, 3'b000);
        bus_write(8'h93, 8'hFF);
        bus_read(8'h93, d);
        check("R2 all locks", d, 8'h07);
    endtask

    task automatic t_readback();
        logic [7:0] d;
        bus_write(8'h91, 8'hF8);
        bus_read(8'h91, d);
        check("R12 clr reads 0", d, 8'h00);
        bus_read(8'h92, d);
        check("R12 dbg reads 0", d, 8'h00);
        bus_read(8'h10, d);
        check("R12 unmapped", d, 8'h00);
    endtask

    task automatic t_flags();
        do_reset();
        @(negedge clk) ext_fault = 2'b10;
        @(negedge clk) ext_fault = 2'b00;
        check("R11 ext set", fault_flags, 4'b1001);
        bus_write(8'h91, 8'h01);
        check("R10 por only", fault_flags, 4'b1000);
        bus_write(8'h92, 8'h01);
        check("R10 err set", fault_flags, 4'b1010);
        bus_write(8'h91, 8'h01);
        check("R10 keeps err", fault_flags, 4'b1010);
        @(negedge clk);
        ext_fault = 2'b01; bus_wr = 1'b1; bus_addr = 8'h91; bus_wdata = 8'h02;
        @(negedge clk);
        ext_fault = 2'b00; bus_wr = 1'b0;
        check("R11 set wins", fault_flags, 4'b0100);
        bus_write(8'h91, 8'h02);
        check("R11 clear all", fault_flags, 4'b0000);
    endtask

    task automatic t_pulse();
        do_reset();
        bus_write(8'h92, 8'h01);
        check("R7 low at start", err_n, 0);
        check("R7 flag", fault_flags[1], 1);
        give_ticks(PT - 1);
        check("R7 still low", err_n, 0);
        give_ticks(1);
        check("R7 released", err_n, 1);
    endtask

    task automatic t_retrigger();
        do_reset();
        bus_write(8'h92, 8'h01);
        give_ticks(30);
        bus_write(8'h92, 8'h01);
        give_ticks(PT - 1);
        check("R9 restarted", err_n, 0);
        give_ticks(1);
        check("R9 end", err_n, 1);
    endtask

    task automatic t_failsafe();
        do_reset();
        bus_write(8'h92, 8'h02);
        check("R5 enter", failsafe, 1);
        bus_write(8'h91, 8'h02);
        bus_write(8'h92, 8'h01);
        @(negedge clk);
        check("R8 err_n high", err_n, 1);
        check("R8 no flag", fault_flags[1], 0);
        bus_write(8'h91, 8'h04);
        check("R6 exit", failsafe, 0);
        bus_write(8'h92, 8'h01);
        check("R6 normal again", err_n, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_lock_gating();
        t_readback();
        t_flags();
        t_pulse();
        t_retrigger();
        t_failsafe();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule